// File: doc/BRIEF.md
# DMA Channel Link and Completion Control

This block sits beside a set of DMA address engines and owns the per-channel bookkeeping that decides what happens when an engine finishes a minor loop. Each channel holds a starting iteration word, a live iteration count and a control word. Every minor-loop completion pulse from an engine counts the live value down. At the right points the block raises a one-cycle link trigger towards another channel, sets the done flag, raises the interrupt line, or drops the channel's hardware request enable.

Linking works on two levels. A link carried in the iteration word fires after every minor loop except the final one. A link carried in the control word fires once, when the major loop completes. Because the minor-link target shares the iteration word with the count, enabling minor linking shrinks the count field from 15 to 9 bits.

A small command port takes an operation code and a channel number. It sets or clears a request enable, clears a done flag, clears an interrupt, or issues a manual start. Each channel's service request is the OR of its gated hardware request, a manual start and an incoming link trigger.

Top module: `dma_link_ctl`

## Requirements
- R1: Iteration word bit 15 set selects minor linking: bits 14:9 name the target channel and bits 8:0 are the count, so a word with count field 3 completes after 3 minor loops whatever its bits 14:9 hold.
- R2: With bit 15 clear the count is bits 14:0, so counts above 511 up to the maximum 32767 run the full number of minor loops before completion.
- R3: With minor linking on, each non-final minor loop produces `linkTrig` high for exactly the one cycle after the edge that sampled `minorDone`, on the target bit only; targets at or above the channel count raise nothing.
- R4: At major completion, control word bit 5 set fires a single one-cycle trigger to the channel in control bits 11:8. The minor link never fires on the final loop, so at most one trigger leaves per completion.
- R5: Control bit 0 set raises `irq` when a minor loop leaves the count equal to the starting count shifted right by one, provided the loop is not the final one.
- R6: Control bit 1 set raises `irq` at major completion, and the live count reloads from the starting word.
- R7: `done` is set at major completion and cleared by command 2 with that channel number; a completion in the same cycle wins.
- R8: Control bit 3 set clears the channel's request enable at completion, overriding any command that cycle; with bit 3 clear the enable is untouched.
- R9: Command 0 sets and command 1 clears the request enable of the written channel; a channel number at or above the channel count, or an op code above 4, changes nothing.
- R10: Command 3 clears the channel's `irq`; an interrupt event in the same cycle wins.
- R11: Command 4 makes `svcReq` high for one cycle for that channel even when its enable is low; `svcReq` is otherwise `hwReq` gated by the enable, ORed with `linkTrig`.
- R12: After reset all flags, enables, counts and triggers are zero.
- R13: A configuration write to a channel loads its starting word, control word and live count, and a `minorDone` for that channel in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgChan | input | CHW | Channel written |
| cfgIter | input | 16 | Starting iteration word |
| cfgCtrl | input | 16 | Control word |
| cmdWe | input | 1 | Command write strobe |
| cmdOp | input | 3 | 0 set enable, 1 clear enable, 2 clear done, 3 clear interrupt, 4 start |
| cmdChan | input | CMDW | Channel number written with the command |
| hwReq | input | NCH | Hardware request per channel |
| minorDone | input | NCH | Minor-loop completion pulse per channel |
| reqEn | output | NCH | Request enable per channel |
| done | output | NCH | Done flag per channel |
| irq | output | NCH | Interrupt per channel |
| linkTrig | output | NCH | One-cycle link trigger per target channel |
| svcReq | output | NCH | Service request per channel |

## Verification
The bench builds the block with four channels. The 6-bit minor-link field and the 4-bit major-link field can then name targets at or above the channel count, which brings the ignored-target path within reach of random stimulus. The small channel set also makes same-cycle collisions frequent: a configuration write against a completion, a clear command against a new event, and two links landing on one target. A directed run of 32767 minor loops covers the largest count.

// File: rtl/dma_link_pkg.sv
package dma_link_pkg;
  // iteration word layout
  localparam int ITER_LINK_BIT = 15;
  localparam int ITER_TGT_LO   = 9;
  localparam int ITER_TGT_W    = 6;
  localparam int LINKED_CNT_W  = 9;
  localparam int CNT_W         = 15;
  // control word layout
  localparam int CTL_HALF_IRQ  = 0;
  localparam int CTL_FULL_IRQ  = 1;
  localparam int CTL_STOP_END  = 3;
  localparam int CTL_MAJ_LINK  = 5;
  localparam int CTL_MAJ_LO    = 8;
  localparam int CTL_MAJ_W     = 4;

  typedef enum logic [2:0] {
    OP_SET_EN   = 3'd0,
    OP_CLR_EN   = 3'd1,
    OP_CLR_DONE = 3'd2,
    OP_CLR_IRQ  = 3'd3,
    OP_START    = 3'd4
  } cmdOpE;

  // control -> datapath strobes, one per channel
  typedef struct packed {
    logic step;
    logic reload;
  } chanStrobeT;

  // datapath -> control decode, one per channel
  typedef struct packed {
    logic                  finalLoop;
    logic                  halfHit;
    logic                  minorLinkOn;
    logic [ITER_TGT_W-1:0] minorTgt;
    logic                  majorLinkOn;
    logic [CTL_MAJ_W-1:0]  majorTgt;
    logic                  halfIrqEn;
    logic                  fullIrqEn;
    logic                  stopAtEnd;
  } chanViewT;

  function automatic logic [CNT_W-1:0] countOf(input logic [15:0] w);
    if (w[ITER_LINK_BIT]) countOf = CNT_W'(w[LINKED_CNT_W-1:0]);
    else                  countOf = w[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/dma_link_dp.sv
module dma_link_dp
  import dma_link_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgWe,
  input  logic [CHW-1:0] cfgChan,
  input  logic [15:0]    cfgIter,
  input  logic [15:0]    cfgCtrl,
  input  chanStrobeT     strobe [NCH],
  output chanViewT       view   [NCH]
);
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [15:0]      begW;
    logic [15:0]      ctlW;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] begCnt;

    assign begCnt = countOf(begW);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        begW <= '0;
        ctlW <= '0;
        cnt  <= '0;
      end else if (cfgWe && cfgChan == CHW'(c)) begin
        begW <= cfgIter;
        ctlW <= cfgCtrl;
        cnt  <= countOf(cfgIter);
      end else if (strobe[c].reload) begin
        cnt <= begCnt;
      end else if (strobe[c].step) begin
        cnt <= cnt - 1'b1;
      end
    end

    always_comb begin
      view[c].finalLoop   = (cnt <= CNT_W'(1));
      view[c].halfHit     = ((cnt - 1'b1) == (begCnt >> 1));
      view[c].minorLinkOn = begW[ITER_LINK_BIT];
      view[c].minorTgt    = begW[ITER_TGT_LO +: ITER_TGT_W];
      view[c].majorLinkOn = ctlW[CTL_MAJ_LINK];
      view[c].majorTgt    = ctlW[CTL_MAJ_LO +: CTL_MAJ_W];
      view[c].halfIrqEn   = ctlW[CTL_HALF_IRQ];
      view[c].fullIrqEn   = ctlW[CTL_FULL_IRQ];
      view[c].stopAtEnd   = ctlW[CTL_STOP_END];
    end
  end
endmodule

// File: rtl/dma_link_ctl_fsm.sv
module dma_link_ctl_fsm
  import dma_link_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CHW  = $clog2(NCH),
  parameter int CMDW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [CHW-1:0]  cfgChan,
  input  logic            cmdWe,
  input  logic [2:0]      cmdOp,
  input  logic [CMDW-1:0] cmdChan,
  input  logic [NCH-1:0]  minorDone,
  input  chanViewT        view   [NCH],
  output chanStrobeT      strobe [NCH],
  output logic [NCH-1:0]  reqEn,
  output logic [NCH-1:0]  done,
  output logic [NCH-1:0]  irq,
  output logic [NCH-1:0]  startPulse,
  output logic [NCH-1:0]  linkTrig
);
  logic [NCH-1:0] enN, doneN, irqN, startN, linkN;
  logic           cmdHit;
  logic [CHW-1:0] cmdIdx;

  assign cmdHit = cmdWe && (32'(cmdChan) < NCH);
  assign cmdIdx = cmdChan[CHW-1:0];

  always_comb begin
    enN    = reqEn;
    doneN  = done;
    irqN   = irq;
    startN = '0;
    linkN  = '0;
    if (cmdHit) begin
      case (cmdOpE'(cmdOp))
        OP_SET_EN:   enN[cmdIdx]    = 1'b1;
        OP_CLR_EN:   enN[cmdIdx]    = 1'b0;
        OP_CLR_DONE: doneN[cmdIdx]  = 1'b0;
        OP_CLR_IRQ:  irqN[cmdIdx]   = 1'b0;
        OP_START:    startN[cmdIdx] = 1'b1;
        default: ;
      endcase
    end
    for (int c = 0; c < NCH; c++) begin
      logic evt;
      evt = minorDone[c] && !(cfgWe && cfgChan == CHW'(c));
      strobe[c].step   = evt && !view[c].finalLoop;
      strobe[c].reload = evt && view[c].finalLoop;
      if (evt) begin
        if (view[c].finalLoop) begin
          doneN[c] = 1'b1;
          if (view[c].fullIrqEn) irqN[c] = 1'b1;
          if (view[c].stopAtEnd) enN[c]  = 1'b0;
          if (view[c].majorLinkOn && 32'(view[c].majorTgt) < NCH)
            linkN[view[c].majorTgt[CHW-1:0]] = 1'b1;
        end else begin
          if (view[c].minorLinkOn && 32'(view[c].minorTgt) < NCH)
            linkN[view[c].minorTgt[CHW-1:0]] = 1'b1;
          if (view[c].halfIrqEn && view[c].halfHit) irqN[c] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqEn      <= '0;
      done       <= '0;
      irq        <= '0;
      startPulse <= '0;
      linkTrig   <= '0;
    end else begin
      reqEn      <= enN;
      done       <= doneN;
      irq        <= irqN;
      startPulse <= startN;
      linkTrig   <= linkN;
    end
  end
endmodule

// File: rtl/dma_link_ctl.sv
module dma_link_ctl
  import dma_link_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CHW  = $clog2(NCH),
  parameter int CMDW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [CHW-1:0]  cfgChan,
  input  logic [15:0]     cfgIter,
  input  logic [15:0]     cfgCtrl,
  input  logic            cmdWe,
  input  logic [2:0]      cmdOp,
  input  logic [CMDW-1:0] cmdChan,
  input  logic [NCH-1:0]  hwReq,
  input  logic [NCH-1:0]  minorDone,
  output logic [NCH-1:0]  reqEn,
  output logic [NCH-1:0]  done,
  output logic [NCH-1:0]  irq,
  output logic [NCH-1:0]  linkTrig,
  output logic [NCH-1:0]  svcReq
);
  chanStrobeT     strobe [NCH];
  chanViewT       view   [NCH];
  logic [NCH-1:0] startPulse;

  dma_link_dp #(.NCH(NCH), .CHW(CHW)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgChan(cfgChan),
    .cfgIter(cfgIter), .cfgCtrl(cfgCtrl), .strobe(strobe), .view(view)
  );

  dma_link_ctl_fsm #(.NCH(NCH), .CHW(CHW), .CMDW(CMDW)) u_fsm (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgChan(cfgChan),
    .cmdWe(cmdWe), .cmdOp(cmdOp), .cmdChan(cmdChan), .minorDone(minorDone),
    .view(view), .strobe(strobe), .reqEn(reqEn), .done(done), .irq(irq),
    .startPulse(startPulse), .linkTrig(linkTrig)
  );

  assign svcReq = (hwReq & reqEn) | startPulse | linkTrig;
endmodule

// File: rtl/dma_link_chk.sv
module dma_link_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           cmdWe,
  input logic [NCH-1:0] hwReq,
  input logic [NCH-1:0] minorDone,
  input logic [NCH-1:0] reqEn,
  input logic [NCH-1:0] done,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] linkTrig,
  input logic [NCH-1:0] svcReq
);
  // R3
  link_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkTrig != '0) |-> ($past(minorDone) != '0));
  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((done & ~$past(done) & ~$past(minorDone)) == '0));
  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((irq & ~$past(irq) & ~$past(minorDone)) == '0));
  // R8
  en_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(reqEn) & ~reqEn) != '0) |-> ($past(cmdWe) || $past(minorDone) != '0));
  // R9
  en_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((reqEn & ~$past(reqEn)) != '0) |-> $past(cmdWe));
  // R11
  svc_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((svcReq & ~(hwReq & reqEn) & ~linkTrig) != '0) |-> $past(cmdWe));
endmodule

bind dma_link_ctl dma_link_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .hwReq(hwReq),
  .minorDone(minorDone), .reqEn(reqEn), .done(done), .irq(irq),
  .linkTrig(linkTrig), .svcReq(svcReq)
);

// File: tb/dma_link_ctl_test.sv
module dma_link_ctl_test;
  localparam int NCH = 4;
  localparam int CHW = 2;
  localparam int CMDW = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 0; logic [CHW-1:0] cfgChan = 0;
  logic [15:0] cfgIter = 0, cfgCtrl = 0;
  logic cmdWe = 0; logic [2:0] cmdOp = 0; logic [CMDW-1:0] cmdChan = 0;
  logic [NCH-1:0] hwReq = 0, minorDone = 0;
  logic [NCH-1:0] reqEn, done, irq, linkTrig, svcReq;

  int total = 0, bad = 0, cycles = 0;

  logic [15:0] mBeg [NCH];
  logic [15:0] mCtl [NCH];
  logic [14:0] mCnt [NCH];
  logic [NCH-1:0] mEn = 0, mDone = 0, mIrq = 0, mStart = 0, mLink = 0;

  dma_link_ctl #(.NCH(NCH), .CHW(CHW), .CMDW(CMDW)) uut (.*);

  always #10 clk = ~clk;

  function automatic logic [14:0] cntOf(input logic [15:0] w);
    return w[15] ? {6'd0, w[8:0]} : w[14:0];
  endfunction

  task automatic chk(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic modelStep();
    logic [NCH-1:0] nl;
    nl = '0;
    mStart = '0;
    if (cmdWe && cmdChan < NCH) begin
      case (cmdOp)
        3'd0: mEn[cmdChan[CHW-1:0]] = 1'b1;
        3'd1: mEn[cmdChan[CHW-1:0]] = 1'b0;
        3'd2: mDone[cmdChan[CHW-1:0]] = 1'b0;
        3'd3: mIrq[cmdChan[CHW-1:0]] = 1'b0;
        3'd4: mStart[cmdChan[CHW-1:0]] = 1'b1;
        default: ;
      endcase
    end
    for (int c = 0; c < NCH; c++) begin
      if (cfgWe && cfgChan == c[CHW-1:0]) begin
        mBeg[c] = cfgIter; mCtl[c] = cfgCtrl; mCnt[c] = cntOf(cfgIter);
      end else if (minorDone[c]) begin
        if (mCnt[c] <= 1) begin
          mCnt[c] = cntOf(mBeg[c]);
          mDone[c] = 1'b1;
          if (mCtl[c][1]) mIrq[c] = 1'b1;
          if (mCtl[c][3]) mEn[c] = 1'b0;
          if (mCtl[c][5] && mCtl[c][11:8] < NCH) nl[mCtl[c][9:8]] = 1'b1;
        end else begin
          mCnt[c] = mCnt[c] - 1;
          if (mBeg[c][15] && mBeg[c][14:9] < NCH) nl[mBeg[c][10:9]] = 1'b1;
          if (mCtl[c][0] && mCnt[c] == (cntOf(mBeg[c]) >> 1)) mIrq[c] = 1'b1;
        end
      end
    end
    mLink = nl;
  endtask

  task automatic step();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    chk("R7 done", done, mDone);
    chk("R5 R6 R10 irq", irq, mIrq);
    chk("R8 R9 reqEn", reqEn, mEn);
    chk("R3 R4 linkTrig", linkTrig, mLink);
    chk("R11 svcReq", svcReq, (hwReq & mEn) | mStart | mLink);
    cfgWe = 0; cmdWe = 0; minorDone = 0;
  endtask

  task automatic cfg(input int ch, input logic [15:0] it, input logic [15:0] ct);
    cfgWe = 1; cfgChan = ch[CHW-1:0]; cfgIter = it; cfgCtrl = ct; step();
  endtask

  task automatic cmd(input int op, input int ch);
    cmdWe = 1; cmdOp = op[2:0]; cmdChan = ch[CMDW-1:0]; step();
  endtask

  task automatic pulse(input int ch, input int n);
    for (int i = 0; i < n; i++) begin minorDone[ch] = 1'b1; step(); end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin mBeg[c] = 0; mCtl[c] = 0; mCnt[c] = 0; end
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset done", done, '0);
    chk("R12 reset irq", irq, '0);
    chk("R12 reset reqEn", reqEn, '0);
    chk("R12 reset link", linkTrig, '0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 linked word: count 3, minor link to channel 2, half irq
    cfg(0, {1'b1, 6'd2, 9'd3}, 16'h0001);
    pulse(0, 2);
    chk("R1 not done yet", done, 4'b0000);
    pulse(0, 1);
    chk("R1 done after 3", done, 4'b0001);
    // R4 major link to 3 with minor link present, full irq, stop at end
    cmd(0, 1);
    cfg(1, {1'b1, 6'd0, 9'd2}, 16'h032A);
    pulse(1, 1);
    chk("R3 minor link to 0", linkTrig, 4'b0001);
    pulse(1, 1);
    chk("R4 major link to 3 only", linkTrig, 4'b1000);
    chk("R8 enable dropped", reqEn & 4'b0010, 4'b0000);
    // R7 R10 clears, R9 out-of-range ignored
    cmd(2, 1); cmd(3, 1); cmd(0, 200); cmd(5, 2);
    chk("R9 ignored cmd", reqEn, 4'b0000);
    // R11 manual start while disabled
    cmd(4, 2);
    chk("R11 start pulse", svcReq, 4'b0100);
    // R13 cfg vs minorDone same cycle
    cfg(2, 16'd2, 16'h0000);
    minorDone[2] = 1'b1; cfgWe = 1; cfgChan = 2; cfgIter = 16'd2; cfgCtrl = 0; step();
    pulse(2, 1);
    chk("R13 dropped pulse", done & 4'b0100, 4'b0000);
    // R2 long counts
    cfg(3, 16'd600, 16'h0000);
    pulse(3, 599);
    chk("R2 600 pending", done & 4'b1000, 4'b0000);
    pulse(3, 1);
    chk("R2 600 done", done & 4'b1000, 4'b1000);
    cmd(2, 3);
    cfg(3, 16'h7FFF, 16'h0002);
    pulse(3, 32766);
    chk("R2 max pending", done & 4'b1000, 4'b0000);
    pulse(3, 1);
    chk("R2 max done", done & 4'b1000, 4'b1000);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 8) begin
        cfgWe = 1; cfgChan = CHW'($urandom % NCH);
        if ($urandom % 2) cfgIter = {1'b1, 6'($urandom % 6), 9'(1 + $urandom % 6)};
        else              cfgIter = {1'b0, 15'(1 + $urandom % 6)};
        cfgCtrl = {4'd0, 4'($urandom % 6), 2'd0, 1'($urandom), 1'b0,
                   1'($urandom), 1'b0, 1'($urandom), 1'($urandom)};
      end
      if (r > 70) begin
        cmdWe = 1; cmdOp = 3'($urandom % 6); cmdChan = CMDW'($urandom % 6);
      end
      minorDone = NCH'($urandom) & NCH'($urandom);
      hwReq = NCH'($urandom);
      step();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule